// File: doc/BRIEF.md
# Six-Read Unlock Sequence Detector

This block watches the host access stream of a battery-free shadowed static memory. It looks for a fixed pattern of six consecutive reads that asks the transfer engine to copy the array into its nonvolatile shadow (a store) or to copy the shadow back into the array (a recall). The first five reads of the pattern are the same for both operations. The sixth address chooses which operation is requested. The reads in the pattern are ordinary array reads and return data as usual. The detector only decides whether, after the sixth read, a request pulse goes to the transfer engine.

An access is one clock cycle with the enable-qualified strobe high. The write-enable level (`wrN`, low means write) sets the access direction. Only the low 14 address bits are compared. A write, or a read off the expected next address, aborts the pattern. An aborting read of the first key address starts a new pattern at once. While the transfer engine reports busy, the detector ignores all accesses and stays at the start. A store-inhibit input from the supply monitor blocks store requests and leaves recall requests untouched.

Top module: `unlock_seq_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, `storeReq` and `recallReq` are low. A pattern that was partly entered before a reset is forgotten.
- R2: Reads (strobe high, `wrN` high) of 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0 raise `storeReq` in the cycle after the clock edge that samples the sixth read.
- R3: The same five leading reads followed by a read of 0x0C63 raise `recallReq` in the same way. The two requests are never high together.
- R4: Address bit 14 is never compared, so keys with bit 14 set match the same as keys with it clear.
- R5: A write (strobe high, `wrN` low) at any point aborts the pattern, even at the expected address, and no request follows.
- R6: A read of any address other than the expected next key aborts the pattern, and no request follows.
- R7: An aborting read whose address is 0x0E38 counts as the first step of a new pattern.
- R8: While `storeInhibit` is high, a completed store pattern issues no request and is consumed. A completed recall pattern still raises `recallReq`.
- R9: While `engineBusy` is high, accesses are ignored, no request is issued, and the pattern returns to its start.
- R10: Cycles with the strobe low do not advance, abort or restart the pattern.
- R11: Each request is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accStrobe | input | 1 | High for one cycle per enable-qualified host access |
| wrN | input | 1 | Access direction: high read, low write |
| addr | input | 15 | Host access address |
| engineBusy | input | 1 | Transfer engine is running a store or recall |
| storeInhibit | input | 1 | Supply below the switch threshold; store requests blocked |
| storeReq | output | 1 | Single-cycle store request to the transfer engine |
| recallReq | output | 1 | Single-cycle recall request to the transfer engine |

## Verification
The walked table first checks clean store and recall patterns, so the sixth key is shown to pick the operation. Bit-14 aliases of the keys show that the high bit is ignored. A write placed at the correct fourth address shows that direction counts as well as address, and a stray read shows the address compare. A repeated first key mid-pattern separates restarting from plain aborting. Idle gaps show that only strobed cycles count. Inhibited store and recall patterns show that the inhibit acts on one operation only. Directed runs place busy and reset in the middle of a pattern and on its sixth access.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;

  // compared address slice and pattern length
  localparam int CMP_W      = 14;
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

  // shared leading keys, in the order they must arrive
  localparam logic [CMP_W-1:0] PREFIX_KEYS [PREFIX_LEN] = '{
    14'h0E38, 14'h31C7, 14'h03E0, 14'h3C1F, 14'h303F
  };
  localparam logic [CMP_W-1:0] STORE_KEY  = 14'h0FC0;
  localparam logic [CMP_W-1:0] RECALL_KEY = 14'h0C63;

  typedef logic [STEP_W-1:0] step_t;

  // strobes from control to datapath
  typedef struct packed {
    logic stepClear;
    logic stepAdvance;
    logic stepRestart;
    logic fireStore;
    logic fireRecall;
  } seqCtrl_t;

  // compare results from datapath to control
  typedef struct packed {
    logic prefixHit;
    logic firstHit;
    logic storeHit;
    logic recallHit;
  } keyHits_t;

endpackage

// File: rtl/unlock_seq_datapath.sv
module unlock_seq_datapath
  import unlock_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CMP_W-1:0] cmpAddr,
  input  seqCtrl_t         ctrl,
  output keyHits_t         hits,
  output step_t            step,
  output logic             storeReq,
  output logic             recallReq
);

  logic [PREFIX_LEN-1:0] keyHit;

  // one comparator per leading key
  for (genvar i = 0; i < PREFIX_LEN; i++) begin : g_key
    assign keyHit[i] = (cmpAddr == PREFIX_KEYS[i]);
  end

  always_comb begin
    hits.prefixHit = 1'b0;
    for (int i = 0; i < PREFIX_LEN; i++) begin
      if (step == step_t'(i)) hits.prefixHit = keyHit[i];
    end
    hits.firstHit  = keyHit[0];
    hits.storeHit  = (cmpAddr == STORE_KEY);
    hits.recallHit = (cmpAddr == RECALL_KEY);
  end

  // number of leading keys already matched
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 step <= '0;
    else if (ctrl.stepClear)   step <= '0;
    else if (ctrl.stepRestart) step <= step_t'(1);
    else if (ctrl.stepAdvance) step <= step + step_t'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storeReq  <= 1'b0;
      recallReq <= 1'b0;
    end else begin
      storeReq  <= ctrl.fireStore;
      recallReq <= ctrl.fireRecall;
    end
  end

  // R2: the step counter never runs past the final key slot
  a_r2_step_bound: assert property (@(posedge clk) disable iff (!rstN)
    step <= step_t'(PREFIX_LEN));

  // R7: a restart leaves exactly one key matched
  a_r7_restart_one: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.stepRestart |=> (step == step_t'(1)));

  // R3: store and recall never requested together
  a_r3_req_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(storeReq && recallReq));

  // R11: pulses last one cycle
  a_r11_store_pulse: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |=> !storeReq);
  a_r11_recall_pulse: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |=> !recallReq);

endmodule

// File: rtl/unlock_seq_ctrl.sv
module unlock_seq_ctrl
  import unlock_seq_pkg::*;
(
  input  logic     accStrobe,
  input  logic     wrN,
  input  logic     engineBusy,
  input  logic     storeInhibit,
  input  step_t    step,
  input  keyHits_t hits,
  output seqCtrl_t ctrl
);

  logic atFinal;
  assign atFinal = (step == step_t'(PREFIX_LEN));

  always_comb begin
    ctrl = '0;
    if (engineBusy) begin
      ctrl.stepClear = 1'b1;
    end else if (accStrobe) begin
      if (!wrN) begin
        ctrl.stepClear = 1'b1;
      end else if (atFinal) begin
        if (hits.storeHit) begin
          ctrl.fireStore = !storeInhibit;
          ctrl.stepClear = 1'b1;
        end else if (hits.recallHit) begin
          ctrl.fireRecall = 1'b1;
          ctrl.stepClear  = 1'b1;
        end else if (hits.firstHit) begin
          ctrl.stepRestart = 1'b1;
        end else begin
          ctrl.stepClear = 1'b1;
        end
      end else if (hits.prefixHit) begin
        ctrl.stepAdvance = 1'b1;
      end else if (hits.firstHit) begin
        ctrl.stepRestart = 1'b1;
      end else begin
        ctrl.stepClear = 1'b1;
      end
    end
  end

endmodule

// File: rtl/unlock_seq_top.sv
module unlock_seq_top
  import unlock_seq_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accStrobe,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              engineBusy,
  input  logic              storeInhibit,
  output logic              storeReq,
  output logic              recallReq
);

  seqCtrl_t ctrl;
  keyHits_t hits;
  step_t    step;

  // bits above the compared slice take no part (R4)
  if (ADDR_W > CMP_W) begin : g_high
    logic unusedHighAddr;
    assign unusedHighAddr = ^addr[ADDR_W-1:CMP_W];
  end

  unlock_seq_ctrl u_ctrl (
    .accStrobe    (accStrobe),
    .wrN          (wrN),
    .engineBusy   (engineBusy),
    .storeInhibit (storeInhibit),
    .step         (step),
    .hits         (hits),
    .ctrl         (ctrl)
  );

  unlock_seq_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmpAddr   (addr[CMP_W-1:0]),
    .ctrl      (ctrl),
    .hits      (hits),
    .step      (step),
    .storeReq  (storeReq),
    .recallReq (recallReq)
  );

  // R8: no store request right after an inhibited cycle
  a_r8_inhibit_blocks: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |-> !$past(storeInhibit));

  // R9: nothing issued from a busy cycle
  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    $past(engineBusy) |-> (!storeReq && !recallReq));

  // R5: a write never completes a pattern
  a_r5_write_blocks: assert property (@(posedge clk) disable iff (!rstN)
    $past(accStrobe && !wrN) |-> (!storeReq && !recallReq));

  // R6: a request always follows a strobed read
  a_r6_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq || recallReq) |-> $past(accStrobe && wrN));

endmodule

// File: tb/unlock_seq_top_tb.sv
module unlock_seq_top_tb;

  localparam logic [14:0] KA = 15'h0E38;
  localparam logic [14:0] KB = 15'h31C7;
  localparam logic [14:0] KC = 15'h03E0;
  localparam logic [14:0] KD = 15'h3C1F;
  localparam logic [14:0] KE = 15'h303F;
  localparam logic [14:0] KS = 15'h0FC0;
  localparam logic [14:0] KR = 15'h0C63;

  // {req tag, strobe wrN busy inhibit, addr, expStore expRecall}
  localparam int NV = 62;
  localparam logic [24:0] VECS [NV] = '{
    // R2 clean store
    {4'd2, 4'b1100, KA, 2'b00}, {4'd2, 4'b1100, KB, 2'b00}, {4'd2, 4'b1100, KC, 2'b00},
    {4'd2, 4'b1100, KD, 2'b00}, {4'd2, 4'b1100, KE, 2'b00}, {4'd2, 4'b1100, KS, 2'b10},
    // R3 clean recall
    {4'd3, 4'b1100, KA, 2'b00}, {4'd3, 4'b1100, KB, 2'b00}, {4'd3, 4'b1100, KC, 2'b00},
    {4'd3, 4'b1100, KD, 2'b00}, {4'd3, 4'b1100, KE, 2'b00}, {4'd3, 4'b1100, KR, 2'b01},
    // R11 pulse gone
    {4'd11, 4'b0100, 15'h0000, 2'b00},
    // R4 bit 14 aliases
    {4'd4, 4'b1100, KA | 15'h4000, 2'b00}, {4'd4, 4'b1100, KB | 15'h4000, 2'b00},
    {4'd4, 4'b1100, KC, 2'b00}, {4'd4, 4'b1100, KD, 2'b00},
    {4'd4, 4'b1100, KE | 15'h4000, 2'b00}, {4'd4, 4'b1100, KS | 15'h4000, 2'b10},
    // R5 write at the expected address
    {4'd5, 4'b1100, KA, 2'b00}, {4'd5, 4'b1100, KB, 2'b00}, {4'd5, 4'b1100, KC, 2'b00},
    {4'd5, 4'b1000, KD, 2'b00}, {4'd5, 4'b1100, KD, 2'b00}, {4'd5, 4'b1100, KE, 2'b00},
    {4'd5, 4'b1100, KS, 2'b00},
    // R6 stray read
    {4'd6, 4'b1100, KA, 2'b00}, {4'd6, 4'b1100, KB, 2'b00}, {4'd6, 4'b1100, 15'h1234, 2'b00},
    {4'd6, 4'b1100, KC, 2'b00}, {4'd6, 4'b1100, KD, 2'b00}, {4'd6, 4'b1100, KE, 2'b00},
    {4'd6, 4'b1100, KS, 2'b00},
    // R7 first key restarts
    {4'd7, 4'b1100, KA, 2'b00}, {4'd7, 4'b1100, KB, 2'b00}, {4'd7, 4'b1100, KC, 2'b00},
    {4'd7, 4'b1100, KA, 2'b00}, {4'd7, 4'b1100, KB, 2'b00}, {4'd7, 4'b1100, KC, 2'b00},
    {4'd7, 4'b1100, KD, 2'b00}, {4'd7, 4'b1100, KE, 2'b00}, {4'd7, 4'b1100, KS, 2'b10},
    // R8 inhibit: store blocked, recall allowed
    {4'd8, 4'b1101, KA, 2'b00}, {4'd8, 4'b1101, KB, 2'b00}, {4'd8, 4'b1101, KC, 2'b00},
    {4'd8, 4'b1101, KD, 2'b00}, {4'd8, 4'b1101, KE, 2'b00}, {4'd8, 4'b1101, KS, 2'b00},
    {4'd8, 4'b1101, KA, 2'b00}, {4'd8, 4'b1101, KB, 2'b00}, {4'd8, 4'b1101, KC, 2'b00},
    {4'd8, 4'b1101, KD, 2'b00}, {4'd8, 4'b1101, KE, 2'b00}, {4'd8, 4'b1101, KR, 2'b01},
    // R10 idle gaps
    {4'd10, 4'b1100, KA, 2'b00}, {4'd10, 4'b0100, 15'h1111, 2'b00},
    {4'd10, 4'b1100, KB, 2'b00}, {4'd10, 4'b0100, 15'h2222, 2'b00},
    {4'd10, 4'b1100, KC, 2'b00}, {4'd10, 4'b1100, KD, 2'b00},
    {4'd10, 4'b1100, KE, 2'b00}, {4'd10, 4'b1100, KS, 2'b10}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accStrobe = 1'b0;
  logic        wrN = 1'b1;
  logic [14:0] addr = '0;
  logic        engineBusy = 1'b0;
  logic        storeInhibit = 1'b0;
  logic        storeReq;
  logic        recallReq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  unlock_seq_top u_dut (
    .clk(clk), .rstN(rstN), .accStrobe(accStrobe), .wrN(wrN), .addr(addr),
    .engineBusy(engineBusy), .storeInhibit(storeInhibit),
    .storeReq(storeReq), .recallReq(recallReq)
  );

  task automatic chk(string tag, logic expS, logic expR);
    checks++;
    if (storeReq !== expS || recallReq !== expR) begin
      failures++;
      $display("FAIL %s: store/recall actual %b%b expected %b%b at %0t",
               tag, storeReq, recallReq, expS, expR, $time);
    end
  endtask

  task automatic access(logic stb, logic wn, logic busy, logic inh, logic [14:0] a,
                        logic expS, logic expR, string tag);
    @(negedge clk);
    accStrobe = stb; wrN = wn; engineBusy = busy; storeInhibit = inh; addr = a;
    @(posedge clk);
    #1;
    chk(tag, expS, expR);
  endtask

  task automatic rd(logic [14:0] a, logic expS, logic expR, string tag);
    access(1'b1, 1'b1, 1'b0, 1'b0, a, expS, expR, tag);
  endtask

  initial begin
    // R1 outputs low under reset
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i][20], VECS[i][19], VECS[i][18], VECS[i][17], VECS[i][16:2],
             VECS[i][1], VECS[i][0], $sformatf("R%0d", int'(VECS[i][24:21])));
    end

    // R9 busy on the fourth access aborts
    rd(KA, 0, 0, "R9"); rd(KB, 0, 0, "R9"); rd(KC, 0, 0, "R9");
    access(1'b1, 1'b1, 1'b1, 1'b0, KD, 0, 0, "R9");
    rd(KE, 0, 0, "R9"); rd(KS, 0, 0, "R9");
    // R9 busy on the sixth access issues nothing
    rd(KA, 0, 0, "R9"); rd(KB, 0, 0, "R9"); rd(KC, 0, 0, "R9");
    rd(KD, 0, 0, "R9"); rd(KE, 0, 0, "R9");
    access(1'b1, 1'b1, 1'b1, 1'b0, KR, 0, 0, "R9");
    // R9 after busy drops a full pattern works
    rd(KA, 0, 0, "R9"); rd(KB, 0, 0, "R9"); rd(KC, 0, 0, "R9");
    rd(KD, 0, 0, "R9"); rd(KE, 0, 0, "R9"); rd(KS, 1, 0, "R9");
    rd(15'h0001, 0, 0, "R11");

    // R1 reset in mid pattern forgets progress
    rd(KA, 0, 0, "R1"); rd(KB, 0, 0, "R1"); rd(KC, 0, 0, "R1");
    rd(KD, 0, 0, "R1"); rd(KE, 0, 0, "R1");
    @(negedge clk);
    accStrobe = 1'b0;
    rstN = 1'b0;
    @(posedge clk);
    #1;
    chk("R1", 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    rd(KS, 0, 0, "R1");
    rd(KR, 0, 0, "R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule